// File: doc/BRIEF.md
# Compressed Trace Stream Decompressor

This block rebuilds a logic-analyzer capture memory from a compressed stream of 32-bit words. Each word carries a one-bit type flag in bit 31 and a 31-bit payload in bits 30:0. A data word stores its payload at the current write pointer and then moves the pointer forward by one. A marker word stores nothing. It loads the write pointer with a new location, so a long run of unchanged samples costs one marker instead of many entries.

Software or a controller pulses `start_i` once capture has stopped. The block then spends one cycle per entry writing zero to the whole memory, raises `done_o` for one cycle, and opens its word input. Words arrive over a valid/ready handshake with at most one word per cycle. While `in_ready_o` is low, an offered word waits at the input: it is neither consumed nor lost, and the sender must hold it until a handshake cycle. `in_ready_o` is low after reset until the first clear finishes, during every clear, and in any cycle where `start_i` is high. Words that arrive before the first marker have no known location. They are written from entry 0 upward, and the sticky flag `unanchored_o` records that this happened.

A separate synchronous read port lets a testbench or a downstream reader inspect the rebuilt contents at any time.

Top module: `trc_unpack`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `in_ready_o` and `unanchored_o` are all 0, and words offered before the first clear are not consumed.
- R2: A `start_i` pulse seen while not clearing makes `busy_o` high for exactly 2^LGMEM cycles, beginning in the cycle after the pulse. `in_ready_o` stays low throughout.
- R3: `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls, and `in_ready_o` rises in that same cycle.
- R4: When a clear finishes, every memory entry reads 0, including entries written before the clear.
- R5: An accepted word with bit 31 = 1 is a marker. Its payload bits LGMEM-1:0 become the write pointer, higher payload bits are ignored, and no memory entry changes.
- R6: An accepted word with bit 31 = 0 writes its payload (bits 30:0) to the entry at the write pointer, and the pointer then increases by one.
- R7: The pointer wraps from 2^LGMEM-1 to 0 on increment.
- R8: Data words accepted after a clear and before any marker are written from entry 0 upward, and they set `unanchored_o`. The flag stays set until the next accepted `start_i` and is not set by data written after a marker.
- R9: A word is consumed only in a cycle where `in_valid_i` and `in_ready_o` are both high, and at most one word is consumed per cycle. A word held valid during a clear is consumed after the clear finishes.
- R10: `rd_data_o` shows the entry addressed by `rd_addr_i` one clock cycle after the address is presented.
- R11: A `start_i` pulse during a clear is ignored and does not lengthen the clear.
- R12: After a clear, the write pointer and the anchoring state restart from 0, whatever the previous stream left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Clear-and-restart command |
| in_valid_i | input | 1 | Word offered |
| in_ready_o | output | 1 | Word can be taken this cycle |
| in_word_i | input | 32 | Bit 31 = marker flag, bits 30:0 = payload |
| busy_o | output | 1 | Memory clear in progress |
| done_o | output | 1 | One-cycle pulse when a clear ends |
| unanchored_o | output | 1 | Data was written before any marker |
| rd_addr_i | input | LGMEM | Read port address |
| rd_data_o | output | 31 | Read port data, one cycle after the address |

## Verification
The bench builds the block with LGMEM = 6, so the memory has 64 entries. This makes a full clear short, and a random stream of a few hundred words wraps the pointer many times and revisits every entry. With only six pointer bits, marker payloads with random upper bits test the truncation rule on nearly every marker. Each clear can be followed by a read-back of all 64 entries within the cycle budget.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned PAY_W  = WORD_W - 1;
  localparam int unsigned FLAG_B = WORD_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_RUN   = 2'd2
  } trc_state_e;

  function automatic logic is_marker(input logic [WORD_W-1:0] w);
    return w[FLAG_B];
  endfunction
endpackage

// File: rtl/trc_mem.sv
module trc_mem #(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 31
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rdata_o <= store[raddr_i];
  end
endmodule

// File: rtl/trc_clear_seq.sv
module trc_clear_seq
  import trc_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          go_o,
  output logic          busy_o,
  output logic          run_o,
  output logic          done_o,
  output logic          clr_we_o,
  output logic [AW-1:0] clr_addr_o
);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  trc_state_e    state_q;
  logic [AW-1:0] cnt_q;
  logic          last_w;

  assign go_o       = start_i && (state_q != ST_CLEAR);
  assign busy_o     = (state_q == ST_CLEAR);
  assign run_o      = (state_q == ST_RUN);
  assign clr_we_o   = busy_o;
  assign clr_addr_o = cnt_q;
  assign last_w     = busy_o && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= last_w;
      if (go_o) begin
        state_q <= ST_CLEAR;
        cnt_q   <= '0;
      end else if (busy_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_w) state_q <= ST_RUN;
      end
    end
  end
endmodule

// File: rtl/trc_word_dec.sv
module trc_word_dec
  import trc_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic              acc_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [PAY_W-1:0]  wr_data_o,
  output logic              unanch_o
);
  logic [AW-1:0] ptr_q;
  logic          anch_q;
  logic          mark_w;

  assign mark_w    = is_marker(word_i);
  assign wr_en_o   = acc_i && !mark_w;
  assign wr_addr_o = ptr_q;
  assign wr_data_o = word_i[PAY_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      anch_q   <= 1'b0;
      unanch_o <= 1'b0;
    end else if (go_i) begin
      ptr_q    <= '0;
      anch_q   <= 1'b0;
      unanch_o <= 1'b0;
    end else if (acc_i) begin
      if (mark_w) begin
        ptr_q  <= word_i[AW-1:0];
        anch_q <= 1'b1;
      end else begin
        ptr_q <= ptr_q + 1'b1;
        if (!anch_q) unanch_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trc_unpack.sv
module trc_unpack
  import trc_pkg::*;
#(
  parameter int unsigned LGMEM = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [31:0]       in_word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              unanchored_o,
  input  logic [LGMEM-1:0]  rd_addr_i,
  output logic [30:0]       rd_data_o
);
  logic             go_w, run_w, clr_we_w, dec_we_w, acc_w;
  logic [LGMEM-1:0] clr_addr_w, dec_addr_w;
  logic [PAY_W-1:0] dec_data_w;
  logic             mem_we;
  logic [LGMEM-1:0] mem_waddr;
  logic [PAY_W-1:0] mem_wdata;

  assign in_ready_o = run_w && !start_i;
  assign acc_w      = in_valid_i && in_ready_o;

  trc_clear_seq #(.AW(LGMEM)) u_clr (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .go_o(go_w),
    .busy_o(busy_o), .run_o(run_w), .done_o(done_o),
    .clr_we_o(clr_we_w), .clr_addr_o(clr_addr_w)
  );

  trc_word_dec #(.AW(LGMEM)) u_dec (
    .clk(clk), .rst_n(rst_n), .go_i(go_w), .acc_i(acc_w),
    .word_i(in_word_i), .wr_en_o(dec_we_w), .wr_addr_o(dec_addr_w),
    .wr_data_o(dec_data_w), .unanch_o(unanchored_o)
  );

  always_comb begin
    if (clr_we_w) begin
      mem_we    = 1'b1;
      mem_waddr = clr_addr_w;
      mem_wdata = '0;
    end else begin
      mem_we    = dec_we_w;
      mem_waddr = dec_addr_w;
      mem_wdata = dec_data_w;
    end
  end

  trc_mem #(.AW(LGMEM), .DW(PAY_W)) u_mem (
    .clk(clk), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(mem_wdata),
    .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
  );
endmodule

// File: rtl/trc_unpack_chk.sv
module trc_unpack_chk #(
  parameter int unsigned LGMEM = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [31:0]      in_word_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             unanchored_o,
  input logic             mem_we,
  input logic [30:0]      mem_wdata
);
  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !in_ready_o); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($fell(busy_o) && in_ready_o == !start_i)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && mem_we) |-> (mem_wdata == '0)); // R4
  AST_MARKER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && in_word_i[31]) |-> !mem_we); // R5
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !(in_valid_i && in_ready_o)) |-> !mem_we); // R9
  AST_UNANCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (unanchored_o && !start_i) |=> unanchored_o); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o)); // R11
endmodule

bind trc_unpack trc_unpack_chk #(.LGMEM(LGMEM)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .in_word_i(in_word_i), .busy_o(busy_o),
  .done_o(done_o), .unanchored_o(unanchored_o), .mem_we(mem_we),
  .mem_wdata(mem_wdata)
);

// File: tb/trc_unpack_bench.sv
module trc_unpack_bench;
  localparam int unsigned LG = 6;
  localparam int unsigned DEPTH = 1 << LG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [31:0]   in_word_i = '0;
  logic          busy_o, done_o, unanchored_o;
  logic [LG-1:0] rd_addr_i = '0;
  logic [30:0]   rd_data_o;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [30:0]   exp_mem [DEPTH];
  logic [LG-1:0] exp_ptr;
  bit            exp_anch, exp_unanch;

  always #2.5 clk = ~clk;

  trc_unpack #(.LGMEM(LG)) u_trc_unpack (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .in_valid_i(in_valid_i),
    .in_ready_o(in_ready_o), .in_word_i(in_word_i), .busy_o(busy_o),
    .done_o(done_o), .unanchored_o(unanchored_o), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [31:0] mk_mark(input logic [30:0] p);
    return {1'b1, p};
  endfunction

  function automatic logic [31:0] mk_data(input logic [30:0] p);
    return {1'b0, p};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
    exp_ptr = '0; exp_anch = 0; exp_unanch = 0;
  endtask

  task automatic model_word(input logic [31:0] w);
    if (w[31]) begin
      exp_ptr = w[LG-1:0]; exp_anch = 1;
    end else begin
      exp_mem[exp_ptr] = w[30:0];
      exp_ptr = exp_ptr + 1'b1;
      if (!exp_anch) exp_unanch = 1;
    end
  endtask

  // R9: word held until a handshake cycle
  task automatic send(input logic [31:0] w);
    bit took;
    in_valid_i = 1'b1; in_word_i = w;
    forever begin
      took = in_ready_o;
      @(negedge clk);
      if (took) break;
    end
    in_valid_i = 1'b0;
    model_word(w);
  endtask

  // R2 R3: pulse start and measure the clear
  task automatic do_clear(input int extra_start_at);
    int n;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    while (busy_o && n < 4 * DEPTH) begin
      chk(!in_ready_o, "R2 ready low while clearing", in_ready_o, 0);
      if (n == extra_start_at) start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      n++;
    end
    chk(n == DEPTH, (extra_start_at >= 0) ? "R11 clear length with extra start" : "R2 clear length", n, DEPTH);
    chk(done_o == 1'b1, "R3 done after clear", done_o, 1);
    chk(in_ready_o == 1'b1, "R3 ready with done", in_ready_o, 1);
    model_clear();
    @(negedge clk);
    chk(done_o == 1'b0, "R3 done single cycle", done_o, 0);
  endtask

  // R4 R10: read back every entry
  task automatic check_mem(input string req);
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr_i = a[LG-1:0];
      @(negedge clk);
      if (rd_data_o !== exp_mem[a]) begin
        bad++;
        chk(0, req, rd_data_o, exp_mem[a]);
      end
    end
    if (bad == 0) chk(1, req, 0, 0);
  endtask

  initial begin
    #(5ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    model_clear();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 0 && done_o == 0, "R1 busy/done after reset", {busy_o, done_o}, 0);
    chk(in_ready_o == 0, "R1 ready low after reset", in_ready_o, 0);
    chk(unanchored_o == 0, "R1 unanchored after reset", unanchored_o, 0);
    rst_n = 1'b1;
    in_valid_i = 1'b1; in_word_i = mk_data(31'h1234);
    repeat (4) begin
      @(negedge clk);
      chk(in_ready_o == 0, "R1 word not taken before clear", in_ready_o, 0);
    end
    in_valid_i = 1'b0;

    do_clear(-1);
    check_mem("R4 memory zero after first clear");

    // R8 R6 unanchored data from entry 0
    send(mk_data(31'h11)); send(mk_data(31'h22));
    @(negedge clk);
    chk(unanchored_o == 1, "R8 unanchored set", unanchored_o, 1);
    // R5 marker with upper payload bits, R6 after marker
    send(mk_mark(31'h7FFF_FFC5));
    send(mk_data(31'h55)); send(mk_data(31'h66));
    // R7 wrap
    send(mk_mark(31'd62));
    send(mk_data(31'hA0)); send(mk_data(31'hA1)); send(mk_data(31'hA2));
    // R9 back-to-back words
    send(mk_data(31'h7FFF_FFFF));
    chk(unanchored_o == 1, "R8 unanchored sticky", unanchored_o, 1);
    check_mem("R5 R6 R7 directed stream contents");

    // R11 start during clear, R12 pointer restart, R9 word held across clear
    do_clear(10);
    chk(unanchored_o == 0, "R8 flag cleared by start", unanchored_o, 0);
    check_mem("R4 memory zero after dirty clear");
    send(mk_mark(31'd3)); send(mk_data(31'h33));
    @(negedge clk);
    chk(unanchored_o == 0, "R8 anchored data leaves flag low", unanchored_o, 0);

    start_i = 1'b1; in_valid_i = 1'b1; in_word_i = mk_data(31'h4A4A);
    @(negedge clk);
    start_i = 1'b0;
    begin
      int n = 0;
      while (!in_ready_o && n < 4 * DEPTH) begin @(negedge clk); n++; end
      chk(n == DEPTH, "R9 held word waits for clear", n, DEPTH);
    end
    model_clear();
    @(negedge clk);
    in_valid_i = 1'b0;
    model_word(mk_data(31'h4A4A));
    send(mk_data(31'h4B4B));
    check_mem("R12 R9 held word lands at entry 0");

    // random streams
    for (int pass = 0; pass < 3; pass++) begin
      do_clear(-1);
      for (int k = 0; k < 250; k++) begin
        logic [30:0] pay;
        pay = 31'($urandom);
        repeat ($urandom % 3) @(negedge clk);
        if (($urandom % 4) == 0) send(mk_mark(pay)); else send(mk_data(pay));
      end
      @(negedge clk);
      chk(unanchored_o == exp_unanch, "R8 random unanchored", unanchored_o, exp_unanch);
      check_mem("R6 R5 random stream contents");
    end
    finish_run();
  end
endmodule